// File: doc/BRIEF.md
# Audio Slot Engine

The block moves audio samples between a sample queue and a one-bit serial line, one frame at a time. A frame holds a configurable number of slots, each `SLOT_W` bits wide, sent or sampled most significant bit first. An external clock generator supplies the timing as two strobes. A frame-sync pulse marks the start of a frame, and a bit pulse marks each bit. In transmit, the engine pulls one sample per slot from the queue and shifts it onto `sd_out`. In receive, it shifts `sd_in` in and pushes one word per slot.

Software controls the engine with a level enable bit and reads back an enable status. Switching off never truncates a frame. If the enable bit is cleared during a frame, the frame runs to its last bit and the status falls only after that. A new enable is accepted only on a fresh rising edge of the enable bit while the status already reads 0. A mono option applies when exactly two slots are configured. Transmit then repeats the slot 0 sample in slot 1, and receive drops slot 1. An output-drive option decides whether the serial line is driven only while the engine is enabled, or as soon as the option is set. A request line pulses once per sample moved, in the configured direction, when requests are enabled.

Top module: `audio_slot_engine`

## Requirements
- R1: The engine turns on only when `cfg_enable` rises from 0 to 1 while `en_status` is 0. `en_status` reads 1 from the cycle after the clock edge that sees the rise.
- R2: Clearing `cfg_enable` while no frame is in progress makes `en_status` 0 one cycle later. Clearing it during a frame lets the frame finish with correct data. `en_status` stays 1 through the final bit strobe and reads 0 in the cycle after it.
- R3: A rising edge of `cfg_enable` while `en_status` is still 1 after a disable is ignored. The engine shuts down at the frame end and stays off, even with `cfg_enable` held at 1, until `cfg_enable` goes to 0 and back to 1.
- R4: A frame starts only on an `fs_strobe` seen while the engine is on and not already inside a frame. While the engine is off, frame-sync and bit strobes cause no pop, no push and no serial data.
- R5: In transmit (`cfg_rx`=0), each slot carries one popped sample, MSB first. The bit presented on `sd_out` during a bit-strobe cycle is the bit the strobe completes. If `tx_valid` is 0 when a slot is loaded, that slot sends all zeros and nothing is popped.
- R6: With `cfg_mono`=1 and `cfg_slots`=2, transmit repeats the slot 0 sample in slot 1 and pops once per frame. With any other slot count, `cfg_mono` has no effect.
- R7: In receive (`cfg_rx`=1), `sd_in` is sampled at each bit strobe, MSB first. `rx_push` pulses for one cycle, with the completed word on `rx_data`, in the cycle after a slot's last bit strobe. With `cfg_mono`=1 and `cfg_slots`=2, slot 1 produces no push.
- R8: `sd_oe` is 0 in receive. In transmit, `sd_oe` equals `cfg_outdrive` OR `en_status`. `sd_out` is 0 whenever no frame is in progress or `sd_oe` is 0.
- R9: After reset, `en_status`, `sd_oe`, `sd_out`, `tx_pop`, `rx_push` and `dma_req` are all 0.
- R10: `dma_req` is 0 while `cfg_dma_en` is 0. Otherwise it pulses once per `tx_pop` in transmit and once per `rx_push` in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enable command (level) |
| cfg_rx | input | 1 | Direction: 0 transmit, 1 receive |
| cfg_mono | input | 1 | Mono option, meaningful with two slots |
| cfg_outdrive | input | 1 | Drive the line regardless of enable |
| cfg_dma_en | input | 1 | Allow request pulses |
| cfg_slots | input | $clog2(MAX_SLOTS+1) | Slots per frame, 1..MAX_SLOTS |
| en_status | output | 1 | Engine on (1) or fully off (0) |
| fs_strobe | input | 1 | Frame-sync pulse |
| bit_strobe | input | 1 | Bit pulse |
| tx_data | input | SLOT_W | Head of transmit queue |
| tx_valid | input | 1 | Transmit queue not empty |
| tx_pop | output | 1 | Consume head of transmit queue |
| rx_data | output | SLOT_W | Received word |
| rx_push | output | 1 | rx_data valid, one cycle |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial output enable |
| dma_req | output | 1 | Transfer request pulse |

## Verification
A corrupted bit or slot counter shows up as a misplaced pop, push or frame end within one slot (`SLOT_W` bit strobes). It also shifts the status fall off the final bit strobe. A stuck drain flag or a bad edge detector shows at `en_status` within a frame length, either as an early fall, a missing fall or an unwanted re-enable. A wrong mono hold register shows on `sd_out` during slot 1 of the very next mono frame.

// File: rtl/audio_slot_engine.sv
module audio_slot_engine #(
  parameter int SLOT_W    = 8,
  parameter int MAX_SLOTS = 4,
  localparam int BW = $clog2(SLOT_W),
  localparam int SW = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_rx,
  input  logic              cfg_mono,
  input  logic              cfg_outdrive,
  input  logic              cfg_dma_en,
  input  logic [SW-1:0]     cfg_slots,
  output logic              en_status,
  input  logic              fs_strobe,
  input  logic              bit_strobe,
  input  logic [SLOT_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_pop,
  output logic [SLOT_W-1:0] rx_data,
  output logic              rx_push,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              dma_req
);

  logic              on_q, drain_q, en_prev_q, in_frame;
  logic [BW-1:0]     bit_q;
  logic [SW-1:0]     slot_q;
  logic [SLOT_W-1:0] sh_q, hold_q, rx_q;
  logic              push_q;

  wire mono_eff  = cfg_mono && (cfg_slots == SW'(2));
  wire slot_end  = in_frame && bit_strobe && (bit_q == BW'(SLOT_W - 1));
  wire frame_end = slot_end && (slot_q == cfg_slots - SW'(1));
  wire next_load = slot_end && !frame_end;
  wire start     = on_q && !drain_q && cfg_enable && !in_frame && fs_strobe;
  wire accept    = !on_q && cfg_enable && !en_prev_q;
  wire shut      = on_q && (drain_q || !cfg_enable) && (!in_frame || frame_end);
  wire load      = !cfg_rx && (start || next_load);
  wire dup       = mono_eff && next_load;
  wire [SLOT_W-1:0] fresh = tx_valid ? tx_data : '0;

  assign en_status = on_q;
  assign tx_pop    = load && !dup && tx_valid;
  assign rx_data   = rx_q;
  assign rx_push   = push_q;
  assign sd_oe     = !cfg_rx && (cfg_outdrive || on_q);
  assign sd_out    = sd_oe && in_frame && sh_q[SLOT_W-1];
  assign dma_req   = cfg_dma_en && (cfg_rx ? push_q : tx_pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q      <= 1'b0;
      drain_q   <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      en_prev_q <= cfg_enable;
      if (accept) begin
        on_q    <= 1'b1;
        drain_q <= 1'b0;
      end else if (shut) begin
        on_q    <= 1'b0;
        drain_q <= 1'b0;
      end else if (on_q && !cfg_enable) begin
        drain_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (start) begin
      in_frame <= 1'b1;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (in_frame && bit_strobe) begin
      bit_q <= slot_end ? '0 : bit_q + BW'(1);
      if (frame_end) begin
        in_frame <= 1'b0;
        slot_q   <= '0;
      end else if (slot_end) begin
        slot_q <= slot_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      rx_q   <= '0;
      push_q <= 1'b0;
    end else begin
      if (load)
        sh_q <= dup ? hold_q : fresh;
      else if (in_frame && bit_strobe)
        sh_q <= {sh_q[SLOT_W-2:0], cfg_rx ? sd_in : 1'b0};
      if (start && !cfg_rx)
        hold_q <= fresh;
      push_q <= cfg_rx && slot_end && !(mono_eff && slot_q == SW'(1));
      if (cfg_rx && slot_end)
        rx_q <= {sh_q[SLOT_W-2:0], sd_in};
    end
  end

  a_r2_frame_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && in_frame && !frame_end) |=> on_q);
  a_r3_off_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> !in_frame);
  a_r4_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> ($past(fs_strobe) && $past(on_q)));
  a_r6_mono_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mono_eff && !cfg_rx && slot_end) |-> !tx_pop);
  a_r7_mono_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rx && mono_eff && slot_end && slot_q == SW'(1)) |=> !rx_push);
  a_r7_rx_only_push: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx |=> !rx_push);
  a_r5_tx_only_pop: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rx |-> !tx_pop);
  a_r10_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |-> !dma_req);

endmodule

// File: tb/sim_audio_slot_engine.sv
module sim_audio_slot_engine;
  localparam int SLOT_W = 8;
  localparam int MAX_SLOTS = 4;
  localparam int SW = $clog2(MAX_SLOTS + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_rx = 0, cfg_mono = 0, cfg_outdrive = 0, cfg_dma_en = 0;
  logic [SW-1:0] cfg_slots = SW'(1);
  logic fs_strobe = 0, bit_strobe = 0, sd_in = 0;
  logic [SLOT_W-1:0] tx_data, rx_data;
  logic tx_valid, tx_pop, rx_push, sd_out, sd_oe, dma_req, en_status;

  logic [7:0] mem [0:63];
  int wr_cnt = 0, rd_ptr = 0;
  bit pop_pend = 0;
  logic [7:0] rx_got [0:7];
  int rx_n = 0, dma_n = 0;
  logic sd_s = 0;
  int total = 0, fails = 0;
  bit done = 0;

  assign tx_valid = rd_ptr < wr_cnt;
  assign tx_data  = mem[rd_ptr[5:0]];

  always #2.5 clk = ~clk;

  audio_slot_engine #(.SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rx(cfg_rx),
    .cfg_mono(cfg_mono), .cfg_outdrive(cfg_outdrive), .cfg_dma_en(cfg_dma_en),
    .cfg_slots(cfg_slots), .en_status(en_status), .fs_strobe(fs_strobe),
    .bit_strobe(bit_strobe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe), .dma_req(dma_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic bs, input logic di);
    @(negedge clk);
    if (pop_pend) rd_ptr++;
    fs_strobe = fs; bit_strobe = bs; sd_in = di;
    #1;
    sd_s = sd_out;
    if (rx_push && rx_n < 8) begin rx_got[rx_n] = rx_data; rx_n++; end
    if (dma_req) dma_n++;
    pop_pend = tx_pop;
  endtask

  task automatic frame(input int ns, input int dis_at, input int reen_at,
                       input logic [7:0] seed, input int gap);
    logic [7:0] exp_w [0:3];
    logic [7:0] got [0:3];
    int idx, k;
    bit m2, on_all;
    m2 = cfg_mono && ns == 2;
    cfg_slots = SW'(ns);
    idx = rd_ptr;
    on_all = 1;
    for (int s = 0; s < ns; s++) begin
      if (cfg_rx) exp_w[s] = seed ^ 8'(s * 60);
      else if (m2 && s == 1) exp_w[s] = exp_w[0];
      else if (idx < wr_cnt) begin exp_w[s] = mem[idx]; idx++; end
      else exp_w[s] = 8'h00;
    end
    rx_n = 0;
    tick(1, 0, 0);
    k = 0;
    for (int s = 0; s < ns; s++)
      for (int b = 0; b < 8; b++) begin
        if (k == dis_at) cfg_enable = 0;
        if (k == reen_at) cfg_enable = 1;
        tick(0, 1, exp_w[s][7-b]);
        got[s][7-b] = sd_s;
        if (dis_at >= 0 && !en_status) on_all = 0;
        k++;
        repeat (gap) tick(0, 0, 0);
      end
    tick(0, 0, 0);
    tick(0, 0, 0);
    if (!cfg_rx) begin
      for (int s = 0; s < ns; s++)
        chk((m2 && s == 1) ? "R6 mono repeat" : "R5 slot data", 32'(got[s]), 32'(exp_w[s]));
      chk(m2 ? "R6 pops per frame" : "R5 pops per frame", 32'(rd_ptr), 32'(idx));
    end else begin
      chk("R7 push count", 32'(rx_n), m2 ? 32'd1 : 32'(ns));
      for (int i = 0; i < (m2 ? 1 : ns); i++)
        chk("R7 rx word", 32'(rx_got[i]), 32'(exp_w[i]));
    end
    if (dis_at >= 0) chk("R2 on through frame", 32'(on_all), 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int p0;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    wr_cnt = 64;
    repeat (3) tick(0, 0, 0);
    chk("R9 status", 32'(en_status), 0);
    chk("R9 oe", 32'(sd_oe), 0);
    chk("R9 out", 32'(sd_out), 0);
    chk("R9 pop", 32'(tx_pop), 0);
    chk("R9 push", 32'(rx_push), 0);
    chk("R9 dma", 32'(dma_req), 0);
    rst_n = 1;
    tick(0, 0, 0);

    cfg_outdrive = 1; tick(0, 0, 0);
    chk("R8 outdrive while off", 32'(sd_oe), 1);
    chk("R8 idle low", 32'(sd_out), 0);
    cfg_outdrive = 0; tick(0, 0, 0);
    chk("R8 no drive while off", 32'(sd_oe), 0);

    p0 = rd_ptr;
    tick(1, 0, 0);
    for (int b = 0; b < 8; b++) tick(0, 1, 0);
    tick(0, 0, 0);
    chk("R4 no pop while off", 32'(rd_ptr), 32'(p0));
    chk("R4 status still off", 32'(en_status), 0);

    cfg_enable = 1;
    chk("R1 before edge", 32'(en_status), 0);
    tick(0, 0, 0);
    chk("R1 on next cycle", 32'(en_status), 1);
    chk("R8 driven when on", 32'(sd_oe), 1);
    chk("R8 idle low when on", 32'(sd_out), 0);

    cfg_dma_en = 1; dma_n = 0; p0 = rd_ptr;
    for (int ns = 1; ns <= 4; ns++) frame(ns, -1, -1, 8'h00, ns % 2);
    cfg_mono = 1;
    frame(2, -1, -1, 8'h00, 0);
    frame(2, -1, -1, 8'h00, 1);
    frame(3, -1, -1, 8'h00, 0);
    frame(1, -1, -1, 8'h00, 0);
    cfg_mono = 0;
    chk("R10 tx requests", 32'(dma_n), 32'(rd_ptr - p0));

    wr_cnt = rd_ptr + 1;
    frame(3, -1, -1, 8'h00, 0);
    wr_cnt = 64;

    cfg_dma_en = 0; dma_n = 0;
    frame(2, -1, -1, 8'h00, 0);
    chk("R10 gated", 32'(dma_n), 0);

    cfg_rx = 1; cfg_dma_en = 1; dma_n = 0;
    tick(0, 0, 0);
    chk("R8 no drive in rx", 32'(sd_oe), 0);
    for (int ns = 1; ns <= 4; ns++) frame(ns, -1, -1, 8'(8'hA5 + ns), ns % 2);
    chk("R10 rx requests", 32'(dma_n), 32'd10);
    cfg_mono = 1;
    frame(2, -1, -1, 8'h5A, 0);
    frame(4, -1, -1, 8'hC3, 0);
    cfg_mono = 0; cfg_rx = 0;

    frame(2, 5, -1, 8'h00, 1);
    chk("R2 off after frame", 32'(en_status), 0);
    tick(0, 0, 0);

    cfg_enable = 1; tick(0, 0, 0);
    chk("R1 re-enable", 32'(en_status), 1);
    frame(3, 3, 9, 8'h00, 0);
    chk("R3 off despite re-enable", 32'(en_status), 0);
    repeat (5) tick(0, 0, 0);
    chk("R3 stays off", 32'(en_status), 0);
    p0 = rd_ptr;
    tick(1, 0, 0);
    for (int b = 0; b < 8; b++) tick(0, 1, 0);
    tick(0, 0, 0);
    chk("R4 ignored frame", 32'(rd_ptr), 32'(p0));
    cfg_enable = 0; tick(0, 0, 0);
    cfg_enable = 1; tick(0, 0, 0);
    chk("R3 fresh edge accepted", 32'(en_status), 1);

    cfg_enable = 0; tick(0, 0, 0);
    chk("R2 off between frames", 32'(en_status), 0);

    rst_n = 0; tick(0, 0, 0);
    chk("R9 status after reset", 32'(en_status), 0);
    chk("R9 oe after reset", 32'(sd_oe), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule